// File: doc/BRIEF.md
# Mesh Dimension-Order Output Port Selector

This block decides where each packet goes when it reaches one router of a two-dimensional mesh. The router's own column and row are given on two plain control pins. Each of the five input ports offers the destination column and row taken from a header flit. For each port, the block subtracts the router's position from the destination to get a signed offset, and it answers with a one-hot request naming one output: west, east, south, north or the local processor.

The block always corrects the column offset fully before it moves along a row. A packet therefore never turns from a vertical hop back to a horizontal one. Because of this, the channels can be numbered so that every route climbs through them in order, and the mesh cannot deadlock. The five inputs are handled in parallel by identical lanes. Each lane has a registered result with one cycle of latency.

Every lane is a valid/ready stream stage. A header transfers when `hdr_valid` and `hdr_ready` are both high at a clock edge. `hdr_ready` is high when the lane's result register is empty, or when that result is being taken in the same cycle. A result transfers when `req_valid` and `req_ready` are both high. While a result is held with `req_ready` low, `req_valid` stays high and `req_port` does not change. A stalled lane never holds up the other lanes. The position pins are sampled at the cycle in which a header is accepted.

Top module: `mesh_route_sel`

## Requirements
- R1: After reset, `req_valid` is low on all five lanes.
- R2: A destination column smaller than the router column gives the west request, bit 4 of the lane's 5-bit `req_port` field. The destination row has no effect.
- R3: A destination column larger than the router column gives the east request, bit 3. The destination row has no effect.
- R4: When the columns are equal, a smaller destination row gives south (bit 2) and a larger one gives north (bit 1).
- R5: When both column and row are equal, the local processor request, bit 0, is given.
- R6: Whenever `req_valid` is high, exactly one bit of that lane's `req_port` field is set.
- R7: A header accepted at clock edge n produces `req_valid` high after edge n, that is, one cycle of latency.
- R8: While `req_valid` is high and `req_ready` is low, `req_port` and `req_valid` hold their values and `hdr_ready` is low.
- R9: The lanes are independent: a stalled lane does not delay or change the results of the other lanes.
- R10: The offsets are signed and one bit wider than the coordinates, so positions at 0 and at the largest coordinate route in the correct direction without wrapping.
- R11: Along any path that follows the returned ports hop by hop, no horizontal hop follows a vertical hop, and the path ends at the destination with a local request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| here_x | input | COORD_W | Column of this router |
| here_y | input | COORD_W | Row of this router |
| hdr_valid | input | 5 | Header offered, one bit per input lane |
| hdr_ready | output | 5 | Lane can take a header |
| hdr_dst_x | input | 5*COORD_W | Destination column per lane, lane i at bits [i*COORD_W +: COORD_W] |
| hdr_dst_y | input | 5*COORD_W | Destination row per lane, same packing |
| req_valid | output | 5 | Request present per lane |
| req_ready | input | 5 | Downstream takes the request |
| req_port | output | 25 | One-hot output request per lane, lane i at bits [i*5 +: 5], bit0 local, bit1 north, bit2 south, bit3 east, bit4 west |

## Verification
A wrong offset sign or a wrong comparison order shows at the port the cycle after the header is accepted. It appears as the wrong one-hot bit or as more than one bit set. A lane whose hold logic is broken lets `req_port` change under a stall within one cycle, or raises `hdr_ready` while the lane is full. The hop-by-hop walks expose an ordering fault as a horizontal move after a vertical one. A sign or width fault shows up as a path that never reaches the destination. Either shows within a few hops.

// File: rtl/route_pkg.sv
package route_pkg;
  localparam int NPORT   = 5;
  localparam int P_LOCAL = 0;
  localparam int P_NORTH = 1;
  localparam int P_SOUTH = 2;
  localparam int P_EAST  = 3;
  localparam int P_WEST  = 4;
  typedef logic [NPORT-1:0] port_req_t;
endpackage

// File: rtl/route_calc.sv
module route_calc
  import route_pkg::*;
#(
  parameter int COORD_W = 4
) (
  input  logic [COORD_W-1:0] here_x,
  input  logic [COORD_W-1:0] here_y,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  output port_req_t          sel
);
  localparam int OFS_W = COORD_W + 1;

  logic signed [OFS_W-1:0] off_x;
  logic signed [OFS_W-1:0] off_y;

  // zero-extend then subtract: one extra bit keeps the sign for all pairs
  assign off_x = $signed({1'b0, dst_x}) - $signed({1'b0, here_x});
  assign off_y = $signed({1'b0, dst_y}) - $signed({1'b0, here_y});

  always_comb begin
    sel = '0;
    if (off_x < 0)      sel[P_WEST]  = 1'b1;
    else if (off_x > 0) sel[P_EAST]  = 1'b1;
    else if (off_y < 0) sel[P_SOUTH] = 1'b1;
    else if (off_y > 0) sel[P_NORTH] = 1'b1;
    else                sel[P_LOCAL] = 1'b1;
  end
endmodule

// File: rtl/route_stage.sv
module route_stage
  import route_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  output logic      in_ready,
  input  port_req_t in_sel,
  output logic      out_valid,
  input  logic      out_ready,
  output port_req_t out_sel
);
  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sel   <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (load)     out_sel   <= in_sel;
    end
  end
endmodule

// File: rtl/mesh_route_sel.sv
module mesh_route_sel
  import route_pkg::*;
#(
  parameter int COORD_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [COORD_W-1:0]       here_x,
  input  logic [COORD_W-1:0]       here_y,
  input  logic [NPORT-1:0]         hdr_valid,
  output logic [NPORT-1:0]         hdr_ready,
  input  logic [NPORT*COORD_W-1:0] hdr_dst_x,
  input  logic [NPORT*COORD_W-1:0] hdr_dst_y,
  output logic [NPORT-1:0]         req_valid,
  input  logic [NPORT-1:0]         req_ready,
  output logic [NPORT*NPORT-1:0]   req_port
);
  for (genvar g = 0; g < NPORT; g++) begin : g_lane
    port_req_t calc_sel;
    port_req_t held_sel;

    route_calc #(.COORD_W(COORD_W)) u_calc (
      .here_x (here_x),
      .here_y (here_y),
      .dst_x  (hdr_dst_x[g*COORD_W +: COORD_W]),
      .dst_y  (hdr_dst_y[g*COORD_W +: COORD_W]),
      .sel    (calc_sel)
    );

    route_stage u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (hdr_valid[g]),
      .in_ready  (hdr_ready[g]),
      .in_sel    (calc_sel),
      .out_valid (req_valid[g]),
      .out_ready (req_ready[g]),
      .out_sel   (held_sel)
    );

    assign req_port[g*NPORT +: NPORT] = held_sel;
  end
endmodule

// File: rtl/route_sel_chk.sv
module route_sel_chk
  import route_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic [NPORT-1:0]       hdr_valid,
  input logic [NPORT-1:0]       hdr_ready,
  input logic [NPORT-1:0]       req_valid,
  input logic [NPORT-1:0]       req_ready,
  input logic [NPORT*NPORT-1:0] req_port
);
  for (genvar g = 0; g < NPORT; g++) begin : g_chk
    AST_ONE_HOT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[g] |-> ($countones(req_port[g*NPORT +: NPORT]) == 1)); // R6
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid[g] && hdr_ready[g]) |=> req_valid[g]); // R7
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[g] && !req_ready[g]) |=> (req_valid[g] && $stable(req_port[g*NPORT +: NPORT]))); // R8
    AST_NO_TAKE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[g] && !req_ready[g]) |-> !hdr_ready[g]); // R8
  end
endmodule

bind mesh_route_sel route_sel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hdr_valid (hdr_valid),
  .hdr_ready (hdr_ready),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_port  (req_port)
);

// File: tb/sim_mesh_route_sel.sv
`timescale 1ns/1ps
module sim_mesh_route_sel;
  localparam int W  = 4;
  localparam int NP = 5;
  localparam int MAXC = (1 << W) - 1;
  localparam logic [4:0] LOC = 5'b00001, NOR = 5'b00010, SOU = 5'b00100,
                         EAS = 5'b01000, WES = 5'b10000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] here_x = '0, here_y = '0;
  logic [NP-1:0] hdr_valid = '0, hdr_ready, req_valid, req_ready = '1;
  logic [NP*W-1:0] hdr_dst_x = '0, hdr_dst_y = '0;
  logic [NP*NP-1:0] req_port;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mesh_route_sel #(.COORD_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .here_x(here_x), .here_y(here_y),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_dst_x(hdr_dst_x), .hdr_dst_y(hdr_dst_y),
    .req_valid(req_valid), .req_ready(req_ready), .req_port(req_port));

  function automatic logic [4:0] expect_port(int mx, int my, int dx, int dy);
    if (dx < mx) return WES;
    if (dx > mx) return EAS;
    if (dy < my) return SOU;
    if (dy > my) return NOR;
    return LOC;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] lane_req(int p);
    return req_port[p*NP +: NP];
  endfunction

  // offer one header on lane p, return the registered request
  task automatic route_one(int p, int mx, int my, int dx, int dy, output logic [4:0] got);
    @(negedge clk);
    here_x = W'(mx); here_y = W'(my);
    hdr_dst_x[p*W +: W] = W'(dx); hdr_dst_y[p*W +: W] = W'(dy);
    hdr_valid[p] = 1'b1;
    @(negedge clk);
    hdr_valid[p] = 1'b0;
    check(req_valid[p], "R7 result one cycle after accept", 32'(req_valid[p]), 1);
    got = lane_req(p);
    check($countones(got) == 1, "R6 single bit set", 32'(got), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(req_valid == '0, "R1 no request in reset", 32'(req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_valid == '0, "R1 no request after reset", 32'(req_valid), 0);
  endtask

  task automatic t_directions();
    logic [4:0] g;
    route_one(0, 8, 8, 3, 12, g); check(g == WES, "R2 west", 32'(g), 32'(WES));
    route_one(1, 8, 8, 3, 2,  g); check(g == WES, "R2 west low row", 32'(g), 32'(WES));
    route_one(2, 5, 5, 9, 1,  g); check(g == EAS, "R3 east", 32'(g), 32'(EAS));
    route_one(3, 5, 5, 9, 14, g); check(g == EAS, "R3 east high row", 32'(g), 32'(EAS));
    route_one(4, 7, 7, 7, 2,  g); check(g == SOU, "R4 south", 32'(g), 32'(SOU));
    route_one(0, 7, 7, 7, 11, g); check(g == NOR, "R4 north", 32'(g), 32'(NOR));
    route_one(1, 6, 9, 6, 9,  g); check(g == LOC, "R5 local", 32'(g), 32'(LOC));
  endtask

  task automatic t_bounds();
    logic [4:0] g;
    route_one(2, MAXC, 0, 0, MAXC, g); check(g == WES, "R10 max to zero col", 32'(g), 32'(WES));
    route_one(3, 0, MAXC, MAXC, 0, g); check(g == EAS, "R10 zero to max col", 32'(g), 32'(EAS));
    route_one(4, 3, MAXC, 3, 0, g);    check(g == SOU, "R10 max to zero row", 32'(g), 32'(SOU));
    route_one(0, 3, 0, 3, MAXC, g);    check(g == NOR, "R10 zero to max row", 32'(g), 32'(NOR));
    route_one(1, MAXC, MAXC, MAXC, MAXC, g); check(g == LOC, "R10 corner local", 32'(g), 32'(LOC));
  endtask

  task automatic t_backpressure();
    logic [4:0] held;
    @(negedge clk);
    req_ready[1] = 1'b0;
    here_x = 4'd4; here_y = 4'd4;
    hdr_dst_x[1*W +: W] = 4'd9; hdr_dst_y[1*W +: W] = 4'd4;  // east
    hdr_dst_x[2*W +: W] = 4'd4; hdr_dst_y[2*W +: W] = 4'd1;  // south
    hdr_valid[1] = 1'b1; hdr_valid[2] = 1'b1;
    @(negedge clk);
    held = lane_req(1);
    check(held == EAS, "R8 stalled lane result", 32'(held), 32'(EAS));
    check(!hdr_ready[1], "R8 stalled lane not ready", 32'(hdr_ready[1]), 0);
    check(lane_req(2) == SOU, "R9 free lane result", 32'(lane_req(2)), 32'(SOU));
    hdr_dst_x[1*W +: W] = 4'd0;                      // would be west
    hdr_dst_x[2*W +: W] = 4'd4; hdr_dst_y[2*W +: W] = 4'd12;  // north
    @(negedge clk);
    check(req_valid[1] && lane_req(1) == EAS, "R8 held under stall", 32'(lane_req(1)), 32'(EAS));
    check(req_valid[2] && lane_req(2) == NOR, "R9 free lane advances", 32'(lane_req(2)), 32'(NOR));
    hdr_valid[2] = 1'b0;
    req_ready[1] = 1'b1;
    @(negedge clk);
    hdr_valid[1] = 1'b0;
    check(req_valid[1] && lane_req(1) == WES, "R8 next header after release", 32'(lane_req(1)), 32'(WES));
    @(negedge clk);
    check(req_valid == '0, "R7 lanes drain", 32'(req_valid), 0);
  endtask

  task automatic t_parallel();
    int mx = 6, my = 10;
    int dxs[NP] = '{6, 1, 12, 6, 6};
    int dys[NP] = '{10, 3, 15, 0, 14};
    @(negedge clk);
    here_x = W'(mx); here_y = W'(my);
    for (int p = 0; p < NP; p++) begin
      hdr_dst_x[p*W +: W] = W'(dxs[p]); hdr_dst_y[p*W +: W] = W'(dys[p]);
    end
    hdr_valid = '1;
    @(negedge clk);
    hdr_valid = '0;
    for (int p = 0; p < NP; p++) begin
      logic [4:0] e;
      e = expect_port(mx, my, dxs[p], dys[p]);
      check(req_valid[p] && lane_req(p) == e, "R9 all lanes at once", 32'(lane_req(p)), 32'(e));
    end
  endtask

  task automatic t_walk(int sx, int sy, int tx, int ty);
    int cx = sx, cy = sy;
    bit went_y = 1'b0, arrived = 1'b0, turned = 1'b0;
    for (int hop = 0; hop < 2 * (MAXC + 1) + 2 && !arrived; hop++) begin
      logic [4:0] g;
      route_one(hop % NP, cx, cy, tx, ty, g);
      case (g)
        EAS: begin cx++; if (went_y) turned = 1'b1; end
        WES: begin cx--; if (went_y) turned = 1'b1; end
        NOR: begin cy++; went_y = 1'b1; end
        SOU: begin cy--; went_y = 1'b1; end
        default: arrived = 1'b1;
      endcase
    end
    check(!turned, "R11 no turn back to X", 32'(turned), 0);
    check(arrived && cx == tx && cy == ty, "R11 path ends at destination",
          32'((cx << 8) | cy), 32'((tx << 8) | ty));
  endtask

  initial begin
    t_reset();
    t_directions();
    t_bounds();
    t_backpressure();
    t_parallel();
    t_walk(0, 0, 9, 13);
    t_walk(15, 2, 1, 0);
    t_walk(4, 15, 4, 3);
    t_walk(12, 7, 12, 7);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule